// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level translation table kept in ordinary memory. The top ten bits of the address select an entry in a directory whose start is given by a base input; that entry either points to a second-level table or, when it is flagged as a large mapping, maps a 4 MB region on its own. In the first case the next ten bits select an entry in the second-level table, which holds the 4 KB frame number. The frame number is joined with the low twelve address bits to form the result.

Requests are accepted one at a time on a valid/ready port and each produces exactly one response. The response carries either the physical address or a fault with its cause. A fault is raised when the directory index is at or beyond a length limit, or when an entry on the walk has its valid flag clear. Table entries are fetched through a single read port that holds each request until the memory acknowledges it, so the walker tolerates any memory latency.

Top module: `pw_walker_top`

## Requirements
- R1: A request's bits [31:22] form the directory index; the first read goes to address `dir_base + 4*index`.
- R2: Entry layout: bit 0 is the valid flag, bit 1 the large-mapping flag, bits [31:12] the pointer or frame; bits [11:2] are ignored. A non-large directory entry sends the second read to `{entry[31:12], va[21:12], 2'b00}`.
- R3: A successful two-read walk returns `{second_entry[31:12], va[11:0]}` with `rsp_fault` low and `rsp_cause` 0.
- R4: A directory entry with bit 0 clear ends the walk after one read with `rsp_fault` high, `rsp_cause` 2 and `rsp_paddr` zero.
- R5: A second-level entry with bit 0 clear gives `rsp_fault` high, `rsp_cause` 3 and `rsp_paddr` zero, after two reads.
- R6: A directory index greater than or equal to `tbl_len` gives `rsp_fault` high and `rsp_cause` 1 with no memory read at all.
- R7: A valid directory entry with bit 1 set ends the walk after one read with `rsp_paddr = {entry[31:22], va[21:0]}`.
- R8: `mem_rd_valid` and `mem_rd_addr` stay steady until a cycle in which `mem_rd_ready` is high; `mem_rd_data` is taken in that cycle.
- R9: After reset `req_ready` is high and `rsp_valid`, `mem_rd_valid` are low; `req_ready` is low from acceptance until the response; `rsp_valid` is a one-cycle pulse that echoes the request address on `rsp_vaddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_base | input | 32 | Physical address of the directory |
| tbl_len | input | 11 | Number of legal directory indices |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request taken when valid |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Walk failed |
| rsp_cause | output | 2 | 0 none, 1 bound, 2 directory invalid, 3 second-level invalid |
| rsp_vaddr | output | 32 | Address of the request being answered |
| rsp_paddr | output | 32 | Physical address, zero on fault |
| mem_rd_valid | output | 1 | Entry read pending |
| mem_rd_addr | output | 32 | Entry read address |
| mem_rd_ready | input | 1 | Memory returns data this cycle |
| mem_rd_data | input | 32 | Entry word |

## Verification
The bench builds the walker with its default geometry of ten directory bits, ten second-level bits and a twelve-bit offset, so that hand-placed entries at known addresses cover every walk outcome. The length limit is changed at run time between a small value, which puts the bound fault and its neighbour index within reach, and the full 1024, which lets the last directory slot be used. Memory latency is swept from zero to three wait cycles, exercising the hold behaviour of the read port both when data comes back at once and when it stalls.

// File: rtl/pw_pkg.sv
package pw_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_BOUND = 2'd1,
    CAUSE_OUTER = 2'd2,
    CAUSE_INNER = 2'd3
  } pw_cause_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_OUT,
    ST_RD_IN,
    ST_RESP
  } pw_state_e;

  localparam int unsigned ENT_VALID_BIT = 0;
  localparam int unsigned ENT_LARGE_BIT = 1;

endpackage

// File: rtl/pw_index_split.sv
module pw_index_split #(
  parameter int unsigned VA_W    = 32,
  parameter int unsigned OUT_W   = 10,
  parameter int unsigned IN_W    = 10,
  parameter int unsigned PA_W    = 32,
  parameter int unsigned ENT_LG  = 2
) (
  input  logic [VA_W-1:0]  vaddr,
  input  logic [PA_W-1:0]  dir_base,
  input  logic [OUT_W:0]   tbl_len,
  output logic             in_bound,
  output logic [PA_W-1:0]  outer_addr
);
  localparam int unsigned LOW_W = VA_W - OUT_W;

  logic [OUT_W-1:0] outer_idx;
  logic [LOW_W-1:0] unused_low;

  assign outer_idx  = vaddr[VA_W-1 -: OUT_W];
  assign unused_low = vaddr[LOW_W-1:0];
  assign in_bound   = {1'b0, outer_idx} < tbl_len;
  assign outer_addr = dir_base + (PA_W'(outer_idx) << ENT_LG);

endmodule

// File: rtl/pw_entry_decode.sv
module pw_entry_decode #(
  parameter int unsigned PA_W    = 32,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned BIG_W   = 22
) (
  input  logic [PA_W-1:0]       entry,
  output logic                  ent_valid,
  output logic                  ent_large,
  output logic [PA_W-OFF_W-1:0] ent_base,
  output logic [PA_W-BIG_W-1:0] ent_big_base
);
  import pw_pkg::*;

  logic [OFF_W-3:0] unused_flags;

  assign ent_valid    = entry[ENT_VALID_BIT];
  assign ent_large    = entry[ENT_LARGE_BIT];
  assign ent_base     = entry[PA_W-1:OFF_W];
  assign ent_big_base = entry[PA_W-1:BIG_W];
  assign unused_flags = entry[OFF_W-1:2];

endmodule

// File: rtl/pw_walk_fsm.sv
module pw_walk_fsm #(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned OUT_W  = 10,
  parameter int unsigned IN_W   = 10,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned PA_W   = 32,
  parameter int unsigned ENT_LG = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             in_bound,
  input  logic [PA_W-1:0]  outer_addr,
  input  logic             mem_rd_ready,
  input  logic             ent_valid,
  input  logic             ent_large,
  input  logic [PA_W-OFF_W-1:0]        ent_base,
  input  logic [PA_W-(IN_W+OFF_W)-1:0] ent_big_base,
  output logic             req_ready,
  output logic             mem_rd_valid,
  output logic [PA_W-1:0]  mem_rd_addr,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [1:0]       rsp_cause,
  output logic [VA_W-1:0]  rsp_vaddr,
  output logic [PA_W-1:0]  rsp_paddr
);
  import pw_pkg::*;

  localparam int unsigned BIG_W = IN_W + OFF_W;

  pw_state_e        state_q;
  logic [VA_W-1:0]  va_q;
  logic [PA_W-1:0]  addr_q;
  logic [PA_W-1:0]  pa_q;
  pw_cause_e        cause_q;
  logic             fault_q;
  logic [IN_W-1:0]  inner_idx;
  logic [PA_W-1:0]  inner_addr;

  assign inner_idx  = va_q[OFF_W +: IN_W];
  assign inner_addr = {ent_base, OFF_W'(OFF_W'(inner_idx) << ENT_LG)};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      addr_q  <= '0;
      pa_q    <= '0;
      cause_q <= CAUSE_NONE;
      fault_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            va_q <= req_vaddr;
            if (!in_bound) begin
              cause_q <= CAUSE_BOUND;
              fault_q <= 1'b1;
              pa_q    <= '0;
              state_q <= ST_RESP;
            end else begin
              addr_q  <= outer_addr;
              state_q <= ST_RD_OUT;
            end
          end
        end
        ST_RD_OUT: begin
          if (mem_rd_ready) begin
            if (!ent_valid) begin
              cause_q <= CAUSE_OUTER;
              fault_q <= 1'b1;
              pa_q    <= '0;
              state_q <= ST_RESP;
            end else if (ent_large) begin
              cause_q <= CAUSE_NONE;
              fault_q <= 1'b0;
              pa_q    <= {ent_big_base, va_q[BIG_W-1:0]};
              state_q <= ST_RESP;
            end else begin
              addr_q  <= inner_addr;
              state_q <= ST_RD_IN;
            end
          end
        end
        ST_RD_IN: begin
          if (mem_rd_ready) begin
            if (!ent_valid) begin
              cause_q <= CAUSE_INNER;
              fault_q <= 1'b1;
              pa_q    <= '0;
            end else begin
              cause_q <= CAUSE_NONE;
              fault_q <= 1'b0;
              pa_q    <= {ent_base, va_q[OFF_W-1:0]};
            end
            state_q <= ST_RESP;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign mem_rd_valid = (state_q == ST_RD_OUT) || (state_q == ST_RD_IN);
  assign mem_rd_addr  = addr_q;
  assign rsp_valid    = (state_q == ST_RESP);
  assign rsp_fault    = fault_q;
  assign rsp_cause    = cause_q;
  assign rsp_vaddr    = va_q;
  assign rsp_paddr    = pa_q;

  // R6: an out-of-range index answers next cycle without touching memory
  p_bound_noread_r6: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_valid && !in_bound) |=>
      (!mem_rd_valid && rsp_valid && rsp_cause == CAUSE_BOUND));

  // R8: a pending read keeps its address until acknowledged
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  // R9: response is a single-cycle pulse followed by idle
  p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> (!rsp_valid && req_ready));

  // R9: idle means no read and no response in flight
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!mem_rd_valid && !rsp_valid));

  // R4: faults never carry an address
  p_fault_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

  // R3: the page offset passes through untouched
  p_offset_r3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == rsp_vaddr[OFF_W-1:0]));

endmodule

// File: rtl/pw_walker_top.sv
module pw_walker_top #(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned OUT_W  = 10,
  parameter int unsigned IN_W   = 10,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned PA_W   = 32,
  parameter int unsigned ENT_LG = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PA_W-1:0]    dir_base,
  input  logic [OUT_W:0]     tbl_len,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic [1:0]         rsp_cause,
  output logic [VA_W-1:0]    rsp_vaddr,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic               mem_rd_valid,
  output logic [PA_W-1:0]    mem_rd_addr,
  input  logic               mem_rd_ready,
  input  logic [PA_W-1:0]    mem_rd_data
);
  localparam int unsigned BIG_W = IN_W + OFF_W;

  logic                  in_bound;
  logic [PA_W-1:0]       outer_addr;
  logic                  ent_valid;
  logic                  ent_large;
  logic [PA_W-OFF_W-1:0] ent_base;
  logic [PA_W-BIG_W-1:0] ent_big_base;

  pw_index_split #(
    .VA_W(VA_W), .OUT_W(OUT_W), .IN_W(IN_W), .PA_W(PA_W), .ENT_LG(ENT_LG)
  ) u_split (
    .vaddr(req_vaddr), .dir_base(dir_base), .tbl_len(tbl_len),
    .in_bound(in_bound), .outer_addr(outer_addr)
  );

  pw_entry_decode #(
    .PA_W(PA_W), .OFF_W(OFF_W), .BIG_W(BIG_W)
  ) u_dec (
    .entry(mem_rd_data), .ent_valid(ent_valid), .ent_large(ent_large),
    .ent_base(ent_base), .ent_big_base(ent_big_base)
  );

  pw_walk_fsm #(
    .VA_W(VA_W), .OUT_W(OUT_W), .IN_W(IN_W), .OFF_W(OFF_W),
    .PA_W(PA_W), .ENT_LG(ENT_LG)
  ) u_fsm (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_vaddr(req_vaddr),
    .in_bound(in_bound), .outer_addr(outer_addr),
    .mem_rd_ready(mem_rd_ready),
    .ent_valid(ent_valid), .ent_large(ent_large),
    .ent_base(ent_base), .ent_big_base(ent_big_base),
    .req_ready(req_ready),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
    .rsp_vaddr(rsp_vaddr), .rsp_paddr(rsp_paddr)
  );

endmodule

// File: tb/pw_walker_top_bench.sv
module pw_walker_top_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] dir_base = 32'h0001_0000;
  logic [10:0] tbl_len = 11'd1024;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        rsp_valid, rsp_fault;
  logic [1:0]  rsp_cause;
  logic [31:0] rsp_vaddr, rsp_paddr;
  logic        mem_rd_valid;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_ready = 1'b0;
  logic [31:0] mem_rd_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pw_walker_top u_pw_walker_top (
    .clk(clk), .rst(rst), .dir_base(dir_base), .tbl_len(tbl_len),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
    .rsp_vaddr(rsp_vaddr), .rsp_paddr(rsp_paddr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ready(mem_rd_ready), .mem_rd_data(mem_rd_data)
  );

  int checks = 0;
  int failures = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // sparse memory model
  logic [31:0] mem [logic [31:0]];
  int lat = 0;
  int wcnt = 0;
  int reads_seen = 0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  always @(negedge clk) begin
    if (mem_rd_ready) begin
      mem_rd_ready = 1'b0;
      wcnt = 0;
    end else if (mem_rd_valid) begin
      if (wcnt >= lat) begin
        mem_rd_ready = 1'b1;
        mem_rd_data  = rd(mem_rd_addr);
        reads_seen++;
      end else begin
        wcnt++;
      end
    end
  end

  typedef struct {
    logic [31:0] va;
    logic        fault;
    logic [1:0]  cause;
    logic [31:0] pa;
    int          nreads;
  } exp_t;
  exp_t q[$];

  // reference walk, written from the requirements
  function automatic exp_t model(input logic [31:0] va);
    exp_t e;
    logic [31:0] o, i;
    e.va = va; e.fault = 1'b1; e.pa = '0;
    if ({1'b0, va[31:22]} >= tbl_len) begin             // R6
      e.cause = 2'd1; e.nreads = 0; return e;
    end
    o = rd(dir_base + 32'(va[31:22]) * 4);              // R1
    e.nreads = 1;
    if (!o[0]) begin e.cause = 2'd2; return e; end      // R4
    if (o[1]) begin                                     // R7
      e.fault = 1'b0; e.cause = 2'd0; e.pa = {o[31:22], va[21:0]}; return e;
    end
    i = rd({o[31:12], va[21:12], 2'b00});               // R2
    e.nreads = 2;
    if (!i[0]) begin e.cause = 2'd3; return e; end      // R5
    e.fault = 1'b0; e.cause = 2'd0; e.pa = {i[31:12], va[11:0]}; // R3
    return e;
  endfunction

  task automatic translate(input logic [31:0] va);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    q.push_back(model(va));
    req_valid = 1'b1;
    req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 busy after accept", {31'b0, req_ready}, 32'd0);
    while (q.size() != 0) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (q.size() == 0) begin
        check("R9 unexpected response", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check("R9 vaddr echo", rsp_vaddr, e.va);
        check("R3-R7 fault", {31'b0, rsp_fault}, {31'b0, e.fault});
        check("R4 R5 R6 cause", {30'b0, rsp_cause}, {30'b0, e.cause});
        check("R3 R7 paddr", rsp_paddr, e.pa);
        check("R6 R7 read count", 32'(reads_seen), 32'(e.nreads));
      end
      reads_seen = 0;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    // directory at 0x10000, second-level tables at 0x20000+
    mem[32'h0001_000C] = {20'h00020, 12'hFF1};   // idx3 -> table, junk flags (R2)
    mem[32'h0002_0014] = {20'hABCDE, 12'h001};   // inner 5 valid
    mem[32'h0002_0018] = {20'h12345, 12'h002};   // inner 6 invalid (large bit ignored)
    mem[32'h0001_0010] = {20'h00030, 12'h002};   // idx4 invalid
    mem[32'h0001_001C] = {10'h155, 10'h3FF, 12'h003}; // idx7 large
    mem[32'h0001_0FFC] = {20'h00040, 12'h001};   // idx1023 -> table
    mem[32'h0004_0FFC] = {20'hFFFFF, 12'h001};   // inner 1023
    for (int k = 8; k < 16; k++) begin
      mem[32'h0001_0000 + k*4] = {20'(32'h50 + k), 12'h001};
      for (int j = 0; j < 4; j++)
        mem[{20'(32'h50 + k), 10'(j), 2'b00}] = {20'(k*16 + j), 11'h0, 1'(j != 2)};
    end

    repeat (3) @(negedge clk);
    check("R9 reset req_ready", {31'b0, req_ready}, 32'd1);
    check("R9 reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
    check("R9 reset mem_rd_valid", {31'b0, mem_rd_valid}, 32'd0);
    rst = 1'b0;

    for (int l = 0; l < 4; l++) begin
      lat = l;
      translate({10'd3, 10'd5, 12'h123});   // R1 R2 R3 two reads
      translate({10'd3, 10'd6, 12'h0FE});   // R5
      translate({10'd4, 10'd1, 12'h001});   // R4
      translate({10'd7, 10'd2, 12'hABC});   // R7
      translate({10'd1023, 10'd1023, 12'hFFF}); // R1 top index
    end

    tbl_len = 11'd8;
    lat = 1;
    translate({10'd8, 10'd0, 12'h010});     // R6 at the limit
    translate({10'd1023, 10'd0, 12'h010});  // R6 far beyond
    translate({10'd7, 10'd0, 12'h010});     // R7 just under limit
    tbl_len = 11'd0;
    translate({10'd0, 10'd0, 12'h000});     // R6 zero length

    tbl_len = 11'd1024;
    dir_base = 32'h0001_0000;
    lfsr = 32'hACE1_1234;
    for (int n = 0; n < 40; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lat = n % 4;
      translate({6'd0, lfsr[3:0], 8'd0, lfsr[5:4], lfsr[17:6]}); // R1-R5 mix
    end

    repeat (4) @(negedge clk);
    check("R9 scoreboard drained", 32'(q.size()), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule